// File: doc/BRIEF.md
# Dual-Rate Priority-Gated Timer

This block keeps two free-running time counters that advance from one shared clock. The fine counter advances once per microsecond. The coarse counter advances once every 64 microseconds. Both rates come from prescaling the system clock. Each counter belongs to one process priority level. The high level owns the fine counter and the low level owns the coarse counter. A request at the low level can therefore neither read nor wait on the fine counter.

A scheduler reads the current time by presenting a priority bit. The block then returns the count that belongs to that priority. The scheduler can also arm a deadline in one of two slots, one per priority. Each slot is compared only against its own counter. The test is a wrap-safe "time after" check on the signed difference. When a slot's counter first moves past its deadline, the block raises a one-cycle wakeup for that slot and disarms the slot.

Top module: `dual_rate_timer`

## Requirements
- R1: While reset is low, and in the cycle after it is released, both counters read 0, both wakeup bits are 0 and both slots are disarmed.
- R2: The fine counter advances by exactly one every CLK_PER_US clock edges, and wraps modulo 2^W. The first step happens on the CLK_PER_US-th rising edge after reset is released.
- R3: The coarse counter advances by one every CLK_PER_US*COARSE_DIV edges, always on the same edge as a fine step, and wraps modulo 2^W.
- R4: `rdValue` shows the fine count when `rdPrio` is 1 and the coarse count when `rdPrio` is 0. The output is combinational and follows `rdPrio` in the same cycle.
- R5: A deadline captured with `armPrio` = 0 is compared only with the coarse count, never with the fine count. A deadline captured with `armPrio` = 1 is compared only with the fine count.
- R6: The counter in question is the fine count for slot 1 and the coarse count for slot 0. `wake[p]` is a one-cycle pulse. It is raised in the cycle in which that counter has just stepped to a value v such that (v − deadline) mod 2^W lies in 1..2^(W−1)−1. The slot is then disarmed and gives no further pulse.
- R7: If a deadline has already passed when it is armed, the wakeup fires on the next step of that slot's counter.
- R8: Arming an armed slot replaces its deadline. If the arm is captured on an edge at which that slot's counter steps, the slot gives no wakeup on that edge.
- R9: The comparison works across counter wraparound. A deadline near 2^W−1 fires after the count wraps to small values, and any value in the half range ahead of the deadline counts as passed.
- R10: A counter value equal to the deadline does not fire. The wakeup comes one step later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (CLK_PER_US cycles per microsecond) |
| rstN | input | 1 | Active-low synchronous reset |
| rdPrio | input | 1 | Read priority: 1 selects the fine count, 0 selects the coarse count |
| rdValue | output | W | Count belonging to the read priority |
| armValid | input | 1 | Capture `armDeadline` into the slot chosen by `armPrio` on this edge |
| armPrio | input | 1 | Slot to arm: 1 = high priority (fine), 0 = low priority (coarse) |
| armDeadline | input | W | Deadline value to arm |
| wake | output | 2 | One-cycle wakeup per slot; bit 1 = high priority, bit 0 = low priority |

## Verification
A prescaler that is one state off shows up as a read value that leads or lags the arithmetic time model. This is visible at the first counter step, within CLK_PER_US cycles. A coarse divider that is off drifts against the fine count by its next coarse step. A deadline register or armed flag in the wrong state shows up as a missing, early, repeated or wrong-slot wakeup. It appears on the first step of the slot's counter after arming. The bench compares both read values and both wakeup bits on every cycle, across wraparound of both counters.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // slot indices: one per process priority level
  localparam int SLOT_LO = 0;  // coarse timer
  localparam int SLOT_HI = 1;  // fine timer
  localparam int N_SLOTS = 2;

  // control -> datapath strobes
  typedef struct packed {
    logic [N_SLOTS-1:0] step;      // counter of slot p advances on this edge
    logic [N_SLOTS-1:0] loadDl;    // capture deadline into slot p
  } tmrStrobe_t;

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CLK_PER_US = 20,
  parameter int COARSE_DIV = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               armValid,
  input  logic               armPrio,
  input  logic [N_SLOTS-1:0] passedNext,
  output tmrStrobe_t         strobe,
  output logic [N_SLOTS-1:0] wake
);

  localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int DIV_W = (COARSE_DIV > 1) ? $clog2(COARSE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(COARSE_DIV - 1);

  logic [PRE_W-1:0] preCnt;
  logic [DIV_W-1:0] divCnt;
  logic             fineTick;
  logic             coarseTick;
  logic [N_SLOTS-1:0] armed;

  // clock -> microsecond prescaler
  assign fineTick = (preCnt == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rstN)          preCnt <= '0;
    else if (fineTick)  preCnt <= '0;
    else                preCnt <= preCnt + 1'b1;
  end

  // microsecond -> coarse divider, stepped only on fine ticks
  assign coarseTick = fineTick && (divCnt == DIV_LAST);

  always_ff @(posedge clk) begin
    if (!rstN)            divCnt <= '0;
    else if (coarseTick)  divCnt <= '0;
    else if (fineTick)    divCnt <= divCnt + 1'b1;
  end

  assign strobe.step[SLOT_HI] = fineTick;
  assign strobe.step[SLOT_LO] = coarseTick;

  // per-priority deadline slots
  for (genvar p = 0; p < N_SLOTS; p++) begin : g_slot
    logic loadThis;
    assign loadThis          = armValid && (armPrio == 1'(p));
    assign strobe.loadDl[p]  = loadThis;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        armed[p] <= 1'b0;
        wake[p]  <= 1'b0;
      end else if (loadThis) begin
        armed[p] <= 1'b1;
        wake[p]  <= 1'b0;
      end else if (strobe.step[p] && armed[p] && passedNext[p]) begin
        armed[p] <= 1'b0;
        wake[p]  <= 1'b1;
      end else begin
        wake[p]  <= 1'b0;
      end
    end

    // R6: a wakeup lasts one cycle
    p_wake_pulse_r6 : assert property (@(posedge clk) disable iff (!rstN)
      wake[p] |=> !wake[p]);

    // R6: a wakeup only comes from a slot that was armed
    p_wake_armed_r6 : assert property (@(posedge clk) disable iff (!rstN)
      $rose(wake[p]) |-> $past(armed[p]));
  end

  // R3: a coarse step never happens without a fine step
  p_coarse_on_fine_r3 : assert property (@(posedge clk) disable iff (!rstN)
    coarseTick |-> fineTick);

endmodule

// File: rtl/tmr_dpath.sv
module tmr_dpath
  import tmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  tmrStrobe_t         strobe,
  input  logic [W-1:0]       armDeadline,
  input  logic               rdPrio,
  output logic [W-1:0]       rdValue,
  output logic [W-1:0]       fineCnt,
  output logic [W-1:0]       coarseCnt,
  output logic [N_SLOTS-1:0] passedNext
);

  logic [W-1:0] cnt [N_SLOTS];
  logic [W-1:0] dl  [N_SLOTS];

  for (genvar p = 0; p < N_SLOTS; p++) begin : g_slot
    logic [W-1:0] incVal;
    logic [W-1:0] diff;

    assign incVal = cnt[p] + 1'b1;
    // wrap-safe "after": signed (incVal - deadline) strictly positive
    assign diff          = incVal - dl[p];
    assign passedNext[p] = !diff[W-1] && (diff != '0);

    always_ff @(posedge clk) begin
      if (!rstN)                cnt[p] <= '0;
      else if (strobe.step[p])  cnt[p] <= incVal;
    end

    always_ff @(posedge clk) begin
      if (!rstN)                  dl[p] <= '0;
      else if (strobe.loadDl[p])  dl[p] <= armDeadline;
    end
  end

  assign fineCnt   = cnt[SLOT_HI];
  assign coarseCnt = cnt[SLOT_LO];
  assign rdValue   = rdPrio ? fineCnt : coarseCnt;

  // R2: the fine count only ever steps by one
  p_fine_step_r2 : assert property (@(posedge clk) disable iff (!rstN)
    (fineCnt != $past(fineCnt)) |-> (fineCnt == $past(fineCnt) + 1'b1));

  // R3: the coarse count only ever steps by one
  p_coarse_step_r3 : assert property (@(posedge clk) disable iff (!rstN)
    (coarseCnt != $past(coarseCnt)) |-> (coarseCnt == $past(coarseCnt) + 1'b1));

  // R3: coarse steps are aligned with fine steps
  p_coarse_aligned_r3 : assert property (@(posedge clk) disable iff (!rstN)
    (coarseCnt != $past(coarseCnt)) |-> (fineCnt != $past(fineCnt)));

endmodule

// File: rtl/dual_rate_timer.sv
module dual_rate_timer
  import tmr_pkg::*;
#(
  parameter int W          = 32,
  parameter int CLK_PER_US = 20,
  parameter int COARSE_DIV = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         rdPrio,
  output logic [W-1:0] rdValue,
  input  logic         armValid,
  input  logic         armPrio,
  input  logic [W-1:0] armDeadline,
  output logic [1:0]   wake
);

  tmrStrobe_t         strobe;
  logic [N_SLOTS-1:0] passedNext;
  logic [W-1:0]       fineCnt;
  logic [W-1:0]       coarseCnt;

  tmr_ctrl #(
    .CLK_PER_US (CLK_PER_US),
    .COARSE_DIV (COARSE_DIV)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .armValid   (armValid),
    .armPrio    (armPrio),
    .passedNext (passedNext),
    .strobe     (strobe),
    .wake       (wake)
  );

  tmr_dpath #(
    .W (W)
  ) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .armDeadline (armDeadline),
    .rdPrio      (rdPrio),
    .rdValue     (rdValue),
    .fineCnt     (fineCnt),
    .coarseCnt   (coarseCnt),
    .passedNext  (passedNext)
  );

  // R6: a high-priority wakeup coincides with a fresh fine count
  p_wake_hi_step_r6 : assert property (@(posedge clk) disable iff (!rstN)
    wake[SLOT_HI] |-> (fineCnt != $past(fineCnt)));

  // R5: a low-priority wakeup coincides with a fresh coarse count
  p_wake_lo_step_r5 : assert property (@(posedge clk) disable iff (!rstN)
    wake[SLOT_LO] |-> (coarseCnt != $past(coarseCnt)));

endmodule

// File: tb/dual_rate_timer_tb_top.sv
module dual_rate_timer_tb_top;

  localparam int W    = 8;
  localparam int CPU  = 2;
  localparam int DIV  = 4;
  localparam int MODV = 256;
  localparam int RUN  = 2600;

  logic         clk = 1'b0;
  logic         rstN;
  logic         rdPrio;
  logic [W-1:0] rdValue;
  logic         armValid;
  logic         armPrio;
  logic [W-1:0] armDeadline;
  logic [1:0]   wake;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dual_rate_timer #(.W(W), .CLK_PER_US(CPU), .COARSE_DIV(DIV)) dut_i (
    .clk(clk), .rstN(rstN), .rdPrio(rdPrio), .rdValue(rdValue),
    .armValid(armValid), .armPrio(armPrio), .armDeadline(armDeadline),
    .wake(wake)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit passed(input int v, input int d);
    int diff;
    diff = (v - d) & (MODV - 1);
    return (diff != 0) && (diff < MODV / 2);
  endfunction

  // bench-side model state
  bit    armedM [2];
  int    dlM    [2];
  string tagM   [2];
  bit    pend;
  int    pendP;
  int    pendD;

  task automatic doArm(input int p, input int d, input string tag);
    armValid    = 1'b1;
    armPrio     = 1'(p);
    armDeadline = W'(d & (MODV - 1));
    pend  = 1'b1;
    pendP = p;
    pendD = d & (MODV - 1);
    tagM[p] = tag;
  endtask

  initial begin
    rstN = 1'b0; rdPrio = 1'b0; armValid = 1'b0; armPrio = 1'b0; armDeadline = '0;
    pend = 1'b0; pendP = 0; pendD = 0;
    armedM[0] = 1'b0; armedM[1] = 1'b0; dlM[0] = 0; dlM[1] = 0;
    tagM[0] = "R6 coarse slot"; tagM[1] = "R6 fine slot";

    repeat (3) @(posedge clk);
    #5;
    rdPrio = 1'b0; #1 chk(rdValue == 0, "R1 coarse in reset", int'(rdValue), 0);
    rdPrio = 1'b1; #1 chk(rdValue == 0, "R1 fine in reset", int'(rdValue), 0);
    chk(wake == 2'b00, "R1 wake in reset", int'(wake), 0);
    @(negedge clk) rstN = 1'b1;

    for (int n = 1; n <= RUN; n++) begin
      int fineE, coarseE, val, expW;
      bit tick;
      @(posedge clk);
      #5;
      fineE   = (n / CPU) % MODV;
      coarseE = (n / (CPU * DIV)) % MODV;

      rdPrio = 1'b0; #1
      chk(rdValue == W'(coarseE), (n == 1) ? "R1 coarse after reset" : "R4 R3 coarse read",
          int'(rdValue), coarseE);
      rdPrio = 1'b1; #1
      chk(rdValue == W'(fineE), (n == 1) ? "R1 fine after reset" : "R4 R2 fine read",
          int'(rdValue), fineE);

      for (int p = 0; p < 2; p++) begin
        tick = (p == 1) ? (n % CPU == 0) : (n % (CPU * DIV) == 0);
        val  = (p == 1) ? fineE : coarseE;
        expW = 0;
        if (pend && pendP == p) begin
          armedM[p] = 1'b1;
          dlM[p]    = pendD;
        end else if (tick && armedM[p] && passed(val, dlM[p])) begin
          expW      = 1;
          armedM[p] = 1'b0;
        end
        chk(wake[p] == 1'(expW), tagM[p], int'(wake[p]), expW);
      end

      pend = 1'b0;
      armValid = 1'b0;
      case (n)
        5:    doArm(1, fineE + 3,   "R6 fine deadline");
        30:   doArm(1, fineE + 2,   "R10 equal value");
        60:   doArm(1, fineE - 5,   "R7 past deadline");
        61:   doArm(1, fineE - 5,   "R8 arm on step edge");
        100:  doArm(0, coarseE + 2, "R5 coarse-only compare");
        200:  doArm(0, coarseE - 3, "R7 coarse past");
        300:  doArm(1, fineE + 100, "R8 replace far");
        310:  doArm(1, fineE + 1,   "R8 replace near");
        400:  doArm(1, 250,         "R9 fine wrap");
        505:  doArm(1, 254,         "R9 fine wrap top");
        515:  doArm(1, 250,         "R9 half range");
        2000: doArm(0, 255,         "R9 coarse wrap");
        default: ;
      endcase
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (RUN + 200) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule